// File: doc/BRIEF.md
# Indexed Store Unit with High-Byte Masking

This block is the store stage of a small 8-bit processor core, covering a group of indexed store opcodes with unusual data behaviour. When an opcode strobe arrives while the unit is idle, it latches the register operands and the 16-bit base address. It picks the index register the opcode uses, forms the effective address and the store value, and then issues one write on a request/acknowledge port.

The store value is never a plain register. It is the selected source register or registers ANDed with the base address high byte plus one. That increment wraps modulo 256. If adding the index to the low byte of the base carries into the high byte, the write address keeps the summed low byte, but its high byte becomes the store value itself and not the incremented high byte. One opcode in the group also loads the stack pointer with the AND of A and X. The new stack pointer value is presented with the completion pulse. Decode of other opcodes and operand fetch take place elsewhere in the core.

Top module: `idx_store_unit`

## Requirements
- R1: After reset, wr_req, done, busy and sp_we are all low.
- R2: Opcodes 0x93 and 0x9F index by Y and store A & X & (base_hi + 1).
- R3: Opcode 0x9E indexes by Y and stores X & (base_hi + 1).
- R4: Opcode 0x9C indexes by X and stores Y & (base_hi + 1).
- R5: Opcode 0x9B stores the same value as 0x9F. It also raises sp_we together with done, with sp_wdata = A & X. No other opcode raises sp_we.
- R6: When base_lo + index is below 0x100, the write address is {base_hi, (base_lo + index) mod 256}.
- R7: When base_lo + index is 0x100 or more, the write address is {store value, (base_lo + index) mod 256}.
- R8: base_hi + 1 wraps, so a base high byte of 0xFF masks the store value to 0x00.
- R9: wr_req rises in the second cycle after the cycle in which the strobe is accepted. The cycle in between is a compute cycle in which busy is high. wr_req, wr_addr and wr_data then hold steady until wr_ack.
- R10: done is high for exactly one cycle, the cycle after the acknowledged request, and wr_req is low in that cycle.
- R11: A strobe with any opcode outside the group, or a strobe while busy, is ignored. No request or done follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opcode strobe |
| opcode | input | 8 | Opcode to execute |
| reg_a | input | 8 | Accumulator |
| reg_x | input | 8 | X index register |
| reg_y | input | 8 | Y index register |
| base_addr | input | 16 | Base address before indexing |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| sp_we | output | 1 | Stack pointer load strobe |
| sp_wdata | output | 8 | New stack pointer value |

## Verification
Assertions check the handshake on every cycle. The compute cycle always comes before the request, the request and its address and data stay stable until acknowledged, done is a single pulse that follows an acknowledge, sp_we never appears without done, and a strobe with a foreign opcode leaves the unit idle. The values themselves are checked only by the bench's scenarios. These cover the masked data for each opcode, the choice of X or Y as index, the high-byte replacement on a page crossing, the wrap of base_hi + 1, the stack pointer value, and a strobe that arrives while the unit is busy.

// File: rtl/isu_pkg.sv
package isu_pkg;
   localparam logic [7:0] OP_SAXY_IND = 8'h93;
   localparam logic [7:0] OP_SAXY_ABS = 8'h9F;
   localparam logic [7:0] OP_SXY_ABS  = 8'h9E;
   localparam logic [7:0] OP_SYX_ABS  = 8'h9C;
   localparam logic [7:0] OP_SAXY_SP  = 8'h9B;

   typedef enum logic [1:0] {SRC_AX = 2'd0, SRC_X = 2'd1, SRC_Y = 2'd2} src_sel_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CALC = 2'd1, ST_WRITE = 2'd2} isu_state_e;

   typedef struct packed {
      logic     valid;
      src_sel_e src;
      logic     idx_is_x;
      logic     load_sp;
   } isu_dec_t;
endpackage

// File: rtl/isu_decode.sv
module isu_decode
   import isu_pkg::*;
(
   input  logic [7:0] opcode,
   output isu_dec_t   dec
);
   always_comb begin
      dec = '{valid: 1'b0, src: SRC_AX, idx_is_x: 1'b0, load_sp: 1'b0};
      case (opcode)
         OP_SAXY_IND, OP_SAXY_ABS: begin
            dec.valid = 1'b1;
         end
         OP_SAXY_SP: begin
            dec.valid   = 1'b1;
            dec.load_sp = 1'b1;
         end
         OP_SXY_ABS: begin
            dec.valid = 1'b1;
            dec.src   = SRC_X;
         end
         OP_SYX_ABS: begin
            dec.valid    = 1'b1;
            dec.src      = SRC_Y;
            dec.idx_is_x = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/isu_addr_data.sv
module isu_addr_data
   import isu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  src_sel_e          src,
   input  logic              idx_is_x,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic [DATA_W-1:0] base_hi,
   input  logic [DATA_W-1:0] base_lo,
   output logic [DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0] addr_lo,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] hi_inc;
   logic [DATA_W-1:0] src_val;
   logic [DATA_W-1:0] idx;
   logic [DATA_W:0]   lo_sum;
   logic              crossed;

   assign hi_inc  = base_hi + DATA_W'(1);
   assign idx     = idx_is_x ? x : y;
   assign lo_sum  = {1'b0, base_lo} + {1'b0, idx};
   assign crossed = lo_sum[DATA_W];
   assign addr_lo = lo_sum[DATA_W-1:0];

   always_comb begin
      case (src)
         SRC_X:   src_val = x;
         SRC_Y:   src_val = y;
         default: src_val = a & x;
      endcase
   end

   assign data = src_val & hi_inc;

   for (genvar i = 0; i < DATA_W; i++) begin : g_hi_mux
      assign addr_hi[i] = crossed ? data[i] : base_hi[i];
   end
endmodule

// File: rtl/idx_store_unit.sv
module idx_store_unit
   import isu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_x,
   input  logic [DATA_W-1:0] reg_y,
   input  logic [ADDR_W-1:0] base_addr,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ack,
   output logic              done,
   output logic              busy,
   output logic              sp_we,
   output logic [DATA_W-1:0] sp_wdata
);
   localparam int HI_LSB = ADDR_W - DATA_W;

   initial begin
      assert (ADDR_W == 2 * DATA_W)
         else $fatal(1, "idx_store_unit: ADDR_W must be twice DATA_W");
   end

   isu_state_e        state_q;
   isu_dec_t          dec_in, dec_q;
   logic [DATA_W-1:0] a_q, x_q, y_q, hi_q, lo_q;
   logic [DATA_W-1:0] nxt_hi, nxt_lo, nxt_data;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, sp_q;
   logic              done_q, sp_we_q;

   isu_decode u_dec (.opcode(opcode), .dec(dec_in));

   isu_addr_data #(.DATA_W(DATA_W)) u_ad (
      .src(dec_q.src), .idx_is_x(dec_q.idx_is_x),
      .a(a_q), .x(x_q), .y(y_q), .base_hi(hi_q), .base_lo(lo_q),
      .addr_hi(nxt_hi), .addr_lo(nxt_lo), .data(nxt_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dec_q   <= '0;
         a_q     <= '0;
         x_q     <= '0;
         y_q     <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         sp_q    <= '0;
         done_q  <= 1'b0;
         sp_we_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         sp_we_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start && dec_in.valid) begin
                  dec_q   <= dec_in;
                  a_q     <= reg_a;
                  x_q     <= reg_x;
                  y_q     <= reg_y;
                  hi_q    <= base_addr[ADDR_W-1:HI_LSB];
                  lo_q    <= base_addr[DATA_W-1:0];
                  state_q <= ST_CALC;
               end
            end
            ST_CALC: begin
               addr_q  <= {nxt_hi, nxt_lo};
               data_q  <= nxt_data;
               sp_q    <= a_q & x_q;
               state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (wr_ack) begin
                  done_q  <= 1'b1;
                  sp_we_q <= dec_q.load_sp;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_req   = (state_q == ST_WRITE);
   assign wr_addr  = addr_q;
   assign wr_data  = data_q;
   assign done     = done_q;
   assign busy     = (state_q != ST_IDLE);
   assign sp_we    = sp_we_q;
   assign sp_wdata = sp_q;
endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [7:0]        opcode,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_ack,
   input logic              done,
   input logic              busy,
   input logic              sp_we
);
   logic op_in_group;
   assign op_in_group = (opcode == 8'h93) || (opcode == 8'h9F) || (opcode == 8'h9E)
                     || (opcode == 8'h9C) || (opcode == 8'h9B);

   a_r9_accept_to_calc: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && op_in_group |=> busy && !wr_req);
   a_r9_calc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !wr_req |=> wr_req);
   a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));
   a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && wr_ack |=> done && !wr_req);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_done_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_req && wr_ack));
   a_r5_sp_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |-> done);
   a_r11_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !op_in_group |=> !busy);
endmodule

bind idx_store_unit isu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_isu_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
   .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
   .done(done), .busy(busy), .sp_we(sp_we)
);

// File: tb/idx_store_unit_test.sv
module idx_store_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = '0, reg_a = '0, reg_x = '0, reg_y = '0;
   logic [15:0] base_addr = '0;
   logic        wr_ack = 1'b0;
   logic        wr_req, done, busy, sp_we;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data, sp_wdata;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic [15:0] addr;
      logic [7:0]  data;
   } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   idx_store_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .base_addr(base_addr),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .done(done), .busy(busy), .sp_we(sp_we), .sp_wdata(sp_wdata)
   );

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Monitor: compares each new write request against the scoreboard
   logic prev_req = 1'b0;
   always @(negedge clk) begin
      if (rst_n && wr_req && !prev_req) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected write", {16'h0, wr_addr}, 32'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(wr_data == e.data, "R2-data", {24'h0, wr_data}, {24'h0, e.data});
            check(wr_addr == e.addr, "R6/R7 addr", {16'h0, wr_addr}, {16'h0, e.addr});
         end
      end
      prev_req = wr_req;
   end

   task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] y, input logic [15:0] base, input int ack_wait,
                         input logic poke_busy);
      logic [7:0] hi1, src, idx, val;
      logic [8:0] sum;
      exp_t e;
      hi1 = base[15:8] + 8'd1;
      idx = (op == 8'h9C) ? x : y;
      src = (op == 8'h9E) ? x : (op == 8'h9C) ? y : (a & x);
      val = src & hi1;
      sum = {1'b0, base[7:0]} + {1'b0, idx};
      e.data = val;
      e.addr = sum[8] ? {val, sum[7:0]} : {base[15:8], sum[7:0]};
      exp_q.push_back(e);
      @(negedge clk);
      opcode = op; reg_a = a; reg_x = x; reg_y = y; base_addr = base; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && !wr_req, "R9 compute cycle", {30'h0, busy, wr_req}, 32'h2);
      @(negedge clk);
      check(wr_req, "R9 request raised", {31'h0, wr_req}, 32'h1);
      for (int i = 0; i < ack_wait; i++) begin
         if (poke_busy && i == 0) begin
            opcode = 8'h9C; start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         check(wr_req && wr_addr == e.addr && wr_data == e.data, "R9 held until ack",
               {15'h0, wr_req, wr_addr}, {15'h0, 1'b1, e.addr});
      end
      wr_ack = 1'b1;
      @(negedge clk);
      wr_ack = 1'b0;
      check(done && !wr_req, "R10 done after ack", {30'h0, done, wr_req}, 32'h2);
      if (op == 8'h9B) begin
         check(sp_we && sp_wdata == (a & x), "R5 stack pointer load",
               {23'h0, sp_we, sp_wdata}, {23'h0, 1'b1, a & x});
      end else begin
         check(!sp_we, "R5 no stack pointer load", {31'h0, sp_we}, 32'h0);
      end
      @(negedge clk);
      check(!done, "R10 done single cycle", {31'h0, done}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!wr_req && !done && !busy && !sp_we, "R1 reset state",
            {28'h0, wr_req, done, busy, sp_we}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!wr_req && !done && !busy && !sp_we, "R1 idle after reset",
            {28'h0, wr_req, done, busy, sp_we}, 32'h0);
      // R2 R6: 0x9F, no crossing
      run_op(8'h9F, 8'hFF, 8'hF0, 8'h10, 16'h1234, 0, 1'b0);
      // R2 R7: 0x9F page crossing
      run_op(8'h9F, 8'hFF, 8'hFF, 8'h20, 16'h12F0, 2, 1'b0);
      // R2: 0x93 with Y index
      run_op(8'h93, 8'h3C, 8'hF7, 8'h05, 16'h7F80, 1, 1'b0);
      // R3: 0x9E, Y index, crossing
      run_op(8'h9E, 8'h00, 8'hAB, 8'hC0, 16'h0E50, 0, 1'b0);
      // R4: 0x9C, X index, no crossing then crossing
      run_op(8'h9C, 8'hFF, 8'h01, 8'h5A, 16'h3EFE, 0, 1'b0);
      run_op(8'h9C, 8'hFF, 8'h10, 8'hFF, 16'h3EFE, 1, 1'b0);
      // R5: 0x9B stores like 0x9F and loads SP
      run_op(8'h9B, 8'hC3, 8'h7E, 8'h04, 16'h5510, 0, 1'b0);
      // R8: high byte 0xFF wraps to a zero mask, with crossing
      run_op(8'h9F, 8'hFF, 8'hFF, 8'h20, 16'hFFF0, 0, 1'b0);
      run_op(8'h9E, 8'h00, 8'hFF, 8'h01, 16'hFF00, 0, 1'b0);
      // R7: maximal sum 0xFF + 0xFF
      run_op(8'h93, 8'hFF, 8'hFF, 8'hFF, 16'h01FF, 0, 1'b0);
      // R11: strobe while busy is ignored
      run_op(8'h9E, 8'h00, 8'h55, 8'h01, 16'h2000, 3, 1'b1);
      repeat (3) @(negedge clk);
      check(!wr_req && !busy, "R11 busy strobe ignored", {30'h0, wr_req, busy}, 32'h0);
      // R11: foreign opcode ignored
      @(negedge clk);
      opcode = 8'hEA; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!busy, "R11 foreign opcode no busy", {31'h0, busy}, 32'h0);
      repeat (3) @(negedge clk);
      check(!wr_req && !done, "R11 foreign opcode no write", {30'h0, wr_req, done}, 32'h0);
      check(exp_q.size() == 0, "R9 all writes seen", exp_q.size(), 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule